// File: doc/BRIEF.md
# SPI Flash Read Target Front-End

This block lets a large DRAM-backed memory answer a host's SPI flash read commands as if it were a serial flash chip. It watches the host's serial clock, chip select and data-in lines with a fast system clock and decodes the command byte. For a read, it gathers a 3-byte address. Because DRAM cannot answer a random read within one SPI bit time, the block splits the memory access across the address phase. A row-open request goes out once the upper address bits are known. A column read of one 16-bit word follows once all but the last address bit are known. The last bit only picks which byte of that word is sent.

Data leaves MSB first on the falling serial clock edge that follows the final address bit, with no dummy cycles for a plain read. While a byte shifts out, the next byte is fetched, so a read may run on for as long as the host keeps chip select low. A discovery-table read uses its own command. It reads from a separate region directly above the 16 MB image and skips eight dummy clocks. While the row is held open, a hold line tells the memory controller to keep it open. A refresh-inhibit line guards the window from the first row request to the start of data.

Top module: `spi_rom_target`

## Requirements
- R1: Command bits are sampled on rising SCK, MSB first, in SPI mode 0. Code 0x03 starts a plain read and code 0x5A starts a discovery-table read.
- R2: On the rising edge that completes address bit 16, a row request is issued with row = {region bit, address[23:8]}. The hold output is high from that request until the column request.
- R3: On the rising edge that completes address bit 23, a column request is issued with column = address[7:1]. The hold output is low in the cycle of the column request.
- R4: The returned word supplies byte address[0]=0 from data bits [7:0] and address[0]=1 from bits [15:8]. For a plain read, the byte's MSB appears on SO from the falling SCK edge right after the final address bit.
- R5: A discovery-table read sets the region bit, which is byte offset 0x1000000. Eight SCK clocks pass after the address before the first data bit.
- R6: After each byte the address increments and wraps within 24 bits, keeping its region. Reads go on with no limit on length.
- R7: Refresh-inhibit rises with the first row request of a transaction and falls when the first data byte starts to shift out.
- R8: Once CS_n is high, within a few system clocks SO output-enable, hold and refresh-inhibit are low and no memory request is issued.
- R9: An unsupported command leaves the SO output-enable low and issues no memory request until CS_n rises.
- R10: A word returned in the same cycle as the final address bit is the word used for the first byte.
- R11: After reset, SO output-enable, hold, refresh-inhibit and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Host serial clock |
| spi_cs_n | input | 1 | Host chip select, active low |
| spi_si | input | 1 | Serial data from host |
| spi_so | output | 1 | Serial data to host |
| spi_so_oe | output | 1 | Output enable for SO; low means tri-stated |
| mem_row_req | output | 1 | One-cycle row-open request |
| mem_row_addr | output | ROW_W | Row: region bit and address bits 23:8 |
| mem_col_req | output | 1 | One-cycle column read request |
| mem_col_addr | output | COL_W | Word column: address bits 7:1 |
| mem_hold | output | 1 | Keep the opened row waiting for the column request |
| mem_refresh_inhibit | output | 1 | Suppress refresh during the address-to-data window |
| mem_rd_valid | input | 1 | Read word valid strobe |
| mem_rd_data | input | 16 | Read word, two bytes |

## Verification
Two events can fall in the same system-clock cycle. One is the memory's word returning. The other is the detected rising edge that carries the last address bit and fixes the byte lane. The bench provokes this by sweeping the memory model's read latency over every value from 1 to 20 cycles. One of those values lands the return exactly on the final-bit cycle. Each read is judged by comparing the shifted-out bytes with an image computed arithmetically from the byte address. A stale word or the wrong lane shows up as a byte mismatch.

// File: rtl/srt_pkg.sv
package srt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_ADDR, ST_DUMMY, ST_DATA, ST_SKIP
  } srt_state_e;

  function automatic logic [7:0] pick_lane(input logic [15:0] w, input logic hi);
    return hi ? w[15:8] : w[7:0];
  endfunction
endpackage

// File: rtl/srt_sync.sv
module srt_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_in
      assign src = d;
    end else begin : g_chain
      assign src = pipe[g-1];
    end
    always_ff @(posedge clk) begin
      if (rst) pipe[g] <= RST_VAL;
      else     pipe[g] <= src;
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/srt_memreq.sv
module srt_memreq #(
  parameter int ROW_W = 17,
  parameter int COL_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             row_go,
  input  logic [ROW_W-1:0] row_val,
  input  logic             col_go,
  input  logic [COL_W-1:0] col_val,
  output logic             row_req,
  output logic [ROW_W-1:0] row_addr,
  output logic             col_req,
  output logic [COL_W-1:0] col_addr,
  output logic             hold
);
  always_ff @(posedge clk) begin
    if (rst || clear) begin
      row_req <= 1'b0;
      col_req <= 1'b0;
      hold    <= 1'b0;
    end else begin
      row_req <= row_go;
      col_req <= col_go;
      if (row_go)      hold <= 1'b1;
      else if (col_go) hold <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      row_addr <= '0;
      col_addr <= '0;
    end else begin
      if (row_go) row_addr <= row_val;
      if (col_go) col_addr <= col_val;
    end
  end
endmodule

// File: rtl/srt_txshift.sv
module srt_txshift (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       fall,
  input  logic       arm,
  input  logic [7:0] byte_in,
  output logic       byte_start,
  output logic       so,
  output logic       so_oe
);
  logic [2:0] fcnt;
  logic [6:0] sh;

  assign byte_start = fall && arm && (fcnt == 3'd0);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fcnt  <= '0;
      sh    <= '0;
      so    <= 1'b0;
      so_oe <= 1'b0;
    end else if (fall && arm) begin
      fcnt <= fcnt + 3'd1;
      if (fcnt == 3'd0) begin
        so    <= byte_in[7];
        sh    <= byte_in[6:0];
        so_oe <= 1'b1;
      end else begin
        so <= sh[6];
        sh <= {sh[5:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_rom_target.sv
module spi_rom_target
  import srt_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int COL_W = 7,
  parameter int SYNC_STAGES = 2,
  parameter int DUMMY_BITS = 8,
  parameter logic [7:0] CMD_READ = 8'h03,
  parameter logic [7:0] CMD_SFDP = 8'h5A,
  localparam int ROW_BITS = ADDR_W - COL_W - 1,
  localparam int ROW_W = ROW_BITS + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             spi_sck,
  input  logic             spi_cs_n,
  input  logic             spi_si,
  output logic             spi_so,
  output logic             spi_so_oe,
  output logic             mem_row_req,
  output logic [ROW_W-1:0] mem_row_addr,
  output logic             mem_col_req,
  output logic [COL_W-1:0] mem_col_addr,
  output logic             mem_hold,
  output logic             mem_refresh_inhibit,
  input  logic             mem_rd_valid,
  input  logic [15:0]      mem_rd_data
);
  localparam int CNT_W = $clog2(ADDR_W + 1);

  logic sck_s, csn_s, si_s, sck_d;
  logic rise, fall, cs_on;

  srt_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst(rst),
    .d({spi_sck, spi_cs_n, spi_si}),
    .q({sck_s, csn_s, si_s})
  );

  always_ff @(posedge clk) begin
    if (rst) sck_d <= 1'b0;
    else     sck_d <= sck_s;
  end

  assign rise  = sck_s && !sck_d;
  assign fall  = !sck_s && sck_d;
  assign cs_on = !csn_s;

  srt_state_e        state;
  logic [CNT_W-1:0]  bcnt;
  logic [6:0]        cmd_sh;
  logic [ADDR_W-2:0] a_sh;
  logic [ADDR_W-1:0] addr_q;
  logic              sfdp_q, lane_ok, pf_row, pf_col, inhibit_q;
  logic [15:0]       word_q;
  logic [7:0]        nxt_byte;
  logic              byte_start;

  logic addr_rise, row_hit, col_hit, last_hit;
  assign addr_rise = cs_on && rise && (state == ST_ADDR);
  assign row_hit   = addr_rise && (bcnt == CNT_W'(ROW_BITS - 1));
  assign col_hit   = addr_rise && (bcnt == CNT_W'(ADDR_W - 2));
  assign last_hit  = addr_rise && (bcnt == CNT_W'(ADDR_W - 1));

  // Request sources: address phase splits row and column; prefetch issues both back to back.
  logic             row_go, col_go;
  logic [ROW_W-1:0] row_val;
  logic [COL_W-1:0] col_val;
  always_comb begin
    row_go  = row_hit;
    col_go  = col_hit;
    row_val = {sfdp_q, a_sh[ROW_BITS-2:0], si_s};
    col_val = {a_sh[COL_W-2:0], si_s};
    if (pf_row) begin
      row_go  = 1'b1;
      row_val = {sfdp_q, addr_q[ADDR_W-1:COL_W+1]};
    end
    if (pf_col) begin
      col_go  = 1'b1;
      col_val = addr_q[COL_W:1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !cs_on) begin
      state     <= ST_IDLE;
      bcnt      <= '0;
      cmd_sh    <= '0;
      a_sh      <= '0;
      addr_q    <= '0;
      sfdp_q    <= 1'b0;
      lane_ok   <= 1'b0;
      pf_row    <= 1'b0;
      pf_col    <= 1'b0;
      inhibit_q <= 1'b0;
    end else begin
      pf_row <= byte_start;
      pf_col <= pf_row;
      if (byte_start) begin
        addr_q    <= addr_q + 1'b1;
        inhibit_q <= 1'b0;
      end
      if (row_hit) inhibit_q <= 1'b1;
      if (state == ST_IDLE) state <= ST_CMD;
      if (rise) begin
        unique case (state)
          ST_CMD: begin
            cmd_sh <= {cmd_sh[5:0], si_s};
            bcnt   <= bcnt + 1'b1;
            if (bcnt == CNT_W'(7)) begin
              bcnt <= '0;
              if ({cmd_sh, si_s} == CMD_READ) begin
                state <= ST_ADDR;  sfdp_q <= 1'b0;
              end else if ({cmd_sh, si_s} == CMD_SFDP) begin
                state <= ST_ADDR;  sfdp_q <= 1'b1;
              end else begin
                state <= ST_SKIP;
              end
            end
          end
          ST_ADDR: begin
            a_sh <= {a_sh[ADDR_W-3:0], si_s};
            bcnt <= bcnt + 1'b1;
            if (last_hit) begin
              bcnt    <= '0;
              addr_q  <= {a_sh, si_s};
              lane_ok <= 1'b1;
              state   <= sfdp_q ? ST_DUMMY : ST_DATA;
            end
          end
          ST_DUMMY: begin
            bcnt <= bcnt + 1'b1;
            if (bcnt == CNT_W'(DUMMY_BITS - 1)) state <= ST_DATA;
          end
          default: ;
        endcase
      end
    end
  end

  // Word capture and lane selection; a word arriving with the final bit is used directly.
  logic [15:0] src_word;
  assign src_word = mem_rd_valid ? mem_rd_data : word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q   <= '0;
      nxt_byte <= '0;
    end else begin
      if (mem_rd_valid) begin
        word_q <= mem_rd_data;
        if (lane_ok) nxt_byte <= pick_lane(mem_rd_data, addr_q[0]);
      end
      if (last_hit) nxt_byte <= pick_lane(src_word, si_s);
    end
  end

  srt_memreq #(.ROW_W(ROW_W), .COL_W(COL_W)) u_memreq (
    .clk(clk), .rst(rst), .clear(!cs_on),
    .row_go(row_go), .row_val(row_val),
    .col_go(col_go), .col_val(col_val),
    .row_req(mem_row_req), .row_addr(mem_row_addr),
    .col_req(mem_col_req), .col_addr(mem_col_addr),
    .hold(mem_hold)
  );

  srt_txshift u_tx (
    .clk(clk), .rst(rst), .clear(!cs_on),
    .fall(fall), .arm(state == ST_DATA),
    .byte_in(nxt_byte), .byte_start(byte_start),
    .so(spi_so), .so_oe(spi_so_oe)
  );

  assign mem_refresh_inhibit = inhibit_q;
endmodule

// File: rtl/srt_check.sv
module srt_check #(
  parameter int SYNC_STAGES = 2,
  localparam int QUIET = SYNC_STAGES + 4
) (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_so_oe,
  input logic mem_row_req,
  input logic mem_col_req,
  input logic mem_hold,
  input logic mem_refresh_inhibit
);
  logic [3:0] hi_cnt;
  always_ff @(posedge clk) begin
    if (rst || !spi_cs_n) hi_cnt <= '0;
    else if (hi_cnt != 4'hF) hi_cnt <= hi_cnt + 4'd1;
  end

  assert_hold_with_row_R2: assert property (@(posedge clk) disable iff (rst)
    mem_row_req |-> mem_hold);

  assert_no_dual_req_R2: assert property (@(posedge clk) disable iff (rst)
    !(mem_row_req && mem_col_req));

  assert_col_ends_hold_R3: assert property (@(posedge clk) disable iff (rst)
    mem_col_req |-> (!mem_hold && $past(mem_hold)));

  assert_inhibit_starts_row_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_refresh_inhibit) |-> mem_row_req);

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (hi_cnt >= 4'(QUIET)) |-> (!spi_so_oe && !mem_hold && !mem_refresh_inhibit
                               && !mem_row_req && !mem_col_req));
endmodule

bind spi_rom_target srt_check #(.SYNC_STAGES(SYNC_STAGES)) u_check (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_so_oe(spi_so_oe),
  .mem_row_req(mem_row_req), .mem_col_req(mem_col_req),
  .mem_hold(mem_hold), .mem_refresh_inhibit(mem_refresh_inhibit)
);

// File: tb/spi_rom_target_test.sv
module spi_rom_target_test;
  localparam int ROW_W = 17;
  localparam int COL_W = 7;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sck = 1'b0, cs_n = 1'b1, si = 1'b0;
  logic so, so_oe, row_req, col_req, hold, inhibit;
  logic [ROW_W-1:0] row_addr;
  logic [COL_W-1:0] col_addr;
  logic rd_valid = 1'b0;
  logic [15:0] rd_data = '0;

  int tests = 0, fails = 0;
  int lat = 4;
  int oe_cnt = 0, row_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_rom_target uut (
    .clk(clk), .rst(rst), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
    .spi_so(so), .spi_so_oe(so_oe),
    .mem_row_req(row_req), .mem_row_addr(row_addr),
    .mem_col_req(col_req), .mem_col_addr(col_addr),
    .mem_hold(hold), .mem_refresh_inhibit(inhibit),
    .mem_rd_valid(rd_valid), .mem_rd_data(rd_data)
  );

  function automatic logic [7:0] img(input logic [24:0] a);
    logic [7:0] v;
    v = a[7:0] + 8'd3 * a[15:8] + 8'd5 * a[23:16];
    return v ^ (a[24] ? 8'hA5 : 8'h00);
  endfunction

  // Memory model with adjustable latency.
  logic [ROW_W-1:0] row_cap = '0;
  logic [COL_W-1:0] col_cap = '0;
  logic [23:0]      waddr = '0;
  int               wait_c = 0;
  always @(posedge clk) begin
    rd_valid <= 1'b0;
    if (row_req) row_cap <= row_addr;
    if (col_req) begin
      col_cap <= col_addr;
      waddr   <= {row_cap, col_addr};
      wait_c  <= lat;
    end else if (wait_c != 0) begin
      wait_c <= wait_c - 1;
      if (wait_c == 1) begin
        rd_valid <= 1'b1;
        rd_data  <= {img({waddr, 1'b1}), img({waddr, 1'b0})};
      end
    end
    if (so_oe)   oe_cnt++;
    if (row_req) row_cnt++;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bit_x(input logic b, output logic r);
    @(negedge clk) si = b;
    repeat (HP) @(negedge clk);
    r = so;
    sck = 1'b1;
    repeat (HP) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic byte_x(input logic [7:0] tx, output logic [7:0] rx);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(tx[i], r);
      rx[i] = r;
    end
  endtask

  task automatic cs_low();
    @(negedge clk) cs_n = 1'b0;
    repeat (HP) @(negedge clk);
  endtask

  task automatic cs_high();
    @(negedge clk) cs_n = 1'b1;
    repeat (12) @(negedge clk);
  endtask

  task automatic do_read(input bit sf, input logic [23:0] a, input int n, input int l, input string tag);
    logic [7:0] rx;
    logic r;
    lat = l;
    cs_low();
    byte_x(sf ? 8'h5A : 8'h03, rx);
    for (int i = 23; i >= 8; i--) bit_x(a[i], r);
    chk(hold && inhibit, "R2 hold and R7 inhibit after bit 16", {hold, inhibit}, 2'b11);
    chk(row_cap == {sf, a[23:8]}, "R2 row address", row_cap, {sf, a[23:8]});
    for (int i = 7; i >= 1; i--) bit_x(a[i], r);
    chk(!hold, "R3 hold released", hold, 0);
    chk(col_cap == a[7:1], "R3 column address", col_cap, a[7:1]);
    bit_x(a[0], r);
    if (sf) byte_x(8'h00, rx);
    for (int k = 0; k < n; k++) begin
      logic [23:0] ak;
      ak = a + 24'(k);
      byte_x(8'h00, rx);
      chk(rx == img({sf, ak}), tag, rx, img({sf, ak}));
      if (k == 0) chk(!inhibit, "R7 inhibit off after first byte", inhibit, 0);
    end
    cs_high();
    chk(!so_oe && !hold && !inhibit, "R8 idle after CS high", {so_oe, hold, inhibit}, 0);
  endtask

  task automatic bad_cmd(input logic [7:0] c);
    logic [7:0] rx;
    int oe0, row0;
    oe0 = oe_cnt;
    row0 = row_cnt;
    cs_low();
    byte_x(c, rx);
    for (int k = 0; k < 4; k++) byte_x(8'h00, rx);
    chk(oe_cnt == oe0, "R9 SO stays off for unsupported command", oe_cnt - oe0, 0);
    chk(row_cnt == row0, "R9 no request for unsupported command", row_cnt - row0, 0);
    cs_high();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rx;
    logic r;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk({so_oe, hold, inhibit, row_req, col_req} == 0, "R11 reset state",
        {so_oe, hold, inhibit, row_req, col_req}, 0);

    do_read(0, 24'h000000, 3, 4, "R1 R4 plain read even start");
    do_read(0, 24'h123457, 3, 6, "R4 plain read odd start");
    do_read(0, 24'h0000FE, 4, 3, "R6 sequential across row");
    do_read(0, 24'hFFFFFE, 4, 5, "R6 sequential wrap");
    do_read(1, 24'h000010, 3, 4, "R1 R5 table read");
    do_read(1, 24'hFFFFFF, 2, 4, "R5 R6 table read wrap");
    for (int l = 1; l <= 20; l++)
      do_read(0, 24'h00ABC0 + 24'(l), 2, l, "R10 latency sweep");

    bad_cmd(8'h9F);
    bad_cmd(8'h0B);

    // R8: abort with the row held open.
    lat = 4;
    cs_low();
    byte_x(8'h03, rx);
    for (int i = 0; i < 18; i++) bit_x(1'b1, r);
    chk(hold, "R8 hold before abort", hold, 1);
    cs_high();
    chk(!hold && !inhibit && !so_oe, "R8 abort in address phase", {hold, inhibit, so_oe}, 0);

    // R8: abort in the middle of a data byte.
    cs_low();
    byte_x(8'h03, rx);
    for (int i = 0; i < 24; i++) bit_x(1'b0, r);
    byte_x(8'h00, rx);
    for (int i = 0; i < 3; i++) bit_x(1'b0, r);
    chk(so_oe, "R4 SO driven during data", so_oe, 1);
    cs_high();
    chk(!so_oe && !hold, "R8 abort in data phase", {so_oe, hold}, 0);

    do_read(0, 24'h4242A1, 3, 7, "R4 read after aborts");

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule